// File: doc/BRIEF.md
# Prioritized Exception Vector Controller

This block sits next to a CPU core and decides which pending exception is serviced next. It gathers three reset-source requests, an unimplemented-opcode trap, a software-interrupt/debug-entry strobe, a single X-class request and a parameterized group of ordinary I-class requests. It compares them against the CPU's I and X mask bits and raises a pending flag whenever something unmasked is active. When the CPU strobes a vector fetch, the block captures the 16-bit vector address of the winner and holds it for as long as the strobe stays high.

A small writable register names one I source by the low byte of its vector. That source is moved to the top of the I group. During a low-power state the block drives a wakeup output. The X request wakes the part even when the X mask is set. An unmasked I request also wakes it. A force input lets test logic inject I requests through the same masking path as real ones.

The control is a three-state machine. ST_IDLE means nothing is pending. ST_PEND means something is pending and no fetch has come yet. ST_SERVE means a vector has been captured and is on the output. The transitions are:
- ST_IDLE to ST_PEND when a request becomes pending.
- ST_IDLE or ST_PEND to ST_SERVE on a fetch strobe while something is pending.
- ST_PEND to ST_IDLE when all requests go away.
- ST_SERVE to ST_PEND or ST_IDLE when the strobe falls, depending on whether something is still pending.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After reset, with no requests, irq_pending, vec_valid and wakeup are 0 and the priority register selects I source 0 (low byte 0xF2).
- R2: The non-I sources win in fixed order, from highest to lowest: power-on/external reset 0xFFFE, clock-monitor failure 0xFFFC, watchdog 0xFFFA, trap 0xFFF8, software interrupt 0xFFF6, X request 0xFFF4. Any of them beats every I source.
- R3: I source k (bit k of req_i) has vector 0xFFF2 - 2k. Among unpromoted I sources the lowest index, which has the highest vector, wins.
- R4: Writing an even byte b with 0xF2 - 2(NUM_I-1) <= b <= 0xF2 to prio_wdata with prio_wr high promotes source (0xF2 - b)/2. When that source is pending it beats all other I sources, but not X or the higher-priority classes.
- R5: A priority write with an odd byte, or with a byte outside that range, is ignored and the previous promotion stays in force.
- R6: While mask_i is 1, no I source, including the promoted one, raises irq_pending or is chosen on a fetch. A fetch with nothing pending leaves vec_valid at 0.
- R7: mask_x blocks only the X request. With mask_x at 1, X neither raises irq_pending nor wins a fetch, and I sources are unaffected.
- R8: Reset sources, trap and software interrupt raise irq_pending regardless of mask_i and mask_x.
- R9: wakeup is 1 only while low_power is 1, and then whenever req_x is 1 (even with mask_x at 1) or an I request is unmasked.
- R10: A vector is captured on the clock edge where vec_fetch is sampled high while pending. vec_valid then goes to 1 and vec_addr stays unchanged while vec_fetch stays high, even if requests change. vec_fetch must be low for one cycle before another capture can happen.
- R11: Bits of force_i are ORed into req_i before masking and arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_por | input | 1 | Power-on/external reset request |
| req_clkmon | input | 1 | Clock-monitor failure request |
| req_wdog | input | 1 | Watchdog timeout request |
| req_trap | input | 1 | Unimplemented-opcode trap |
| req_swi | input | 1 | Software interrupt / debug entry |
| req_x | input | 1 | X-class request |
| req_i | input | NUM_I | I-class requests, bit k is source k |
| force_i | input | NUM_I | Test injection of I requests |
| mask_i | input | 1 | CPU I mask bit |
| mask_x | input | 1 | CPU X mask bit |
| low_power | input | 1 | Core is in stop or wait |
| prio_wr | input | 1 | Priority register write enable |
| prio_wdata | input | 8 | Vector low byte to promote |
| vec_fetch | input | 1 | CPU vector fetch strobe |
| irq_pending | output | 1 | An unmasked request is active |
| vec_valid | output | 1 | vec_addr holds a captured vector |
| vec_addr | output | 16 | Captured vector address |
| wakeup | output | 1 | Wake from low-power state |

## Verification
The bench goes after the two edges of the priority ladder: the lowest-index I source against a promoted one, and X against the promoted source. A design with the promotion placed above X would return 0xFFE8 where 0xFFF4 is expected. It writes odd, too-high and too-low priority bytes; a design that accepts any of them changes which I source wins. It holds vec_fetch high while a reset request arrives; a design that recaptures would switch to 0xFFFE mid-fetch. It also checks that a masked X still wakes and that a masked promoted source stays silent.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_SERVE = 2'd2
    } exc_state_e;

    localparam logic [15:0] VEC_POR    = 16'hFFFE;
    localparam logic [15:0] VEC_CLKMON = 16'hFFFC;
    localparam logic [15:0] VEC_WDOG   = 16'hFFFA;
    localparam logic [15:0] VEC_TRAP   = 16'hFFF8;
    localparam logic [15:0] VEC_SWI    = 16'hFFF6;
    localparam logic [15:0] VEC_XREQ   = 16'hFFF4;
    localparam logic [15:0] VEC_I_TOP  = 16'hFFF2;
    localparam logic [7:0]  PRIO_RESET = 8'hF2;
endpackage

// File: rtl/exc_prio_reg.sv
module exc_prio_reg
    import exc_vec_pkg::*;
#(
    parameter int NUM_I = 8,
    parameter int IDX_W = $clog2(NUM_I)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [IDX_W-1:0] promo_idx
);
    localparam int LOW_MIN = 242 - 2 * (NUM_I - 1);

    logic [7:0] prio_q;
    logic       wr_ok;

    // accept only even low bytes that name an existing I source
    assign wr_ok = wr_en && !wr_data[0]
                   && (int'(wr_data) <= 242) && (int'(wr_data) >= LOW_MIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= PRIO_RESET;
        end else if (wr_ok) begin
            prio_q <= wr_data;
        end
    end

    assign promo_idx = IDX_W'((PRIO_RESET - prio_q) >> 1);
endmodule

// File: rtl/exc_i_arbiter.sv
module exc_i_arbiter #(
    parameter int NUM_I = 8,
    parameter int IDX_W = $clog2(NUM_I)
) (
    input  logic [NUM_I-1:0] req,
    input  logic [IDX_W-1:0] promo_idx,
    output logic             any,
    output logic [IDX_W-1:0] win_idx
);
    logic found;

    always_comb begin
        any     = |req;
        win_idx = '0;
        found   = 1'b0;
        // lowest index carries the highest vector
        for (int k = 0; k < NUM_I; k++) begin
            if (!found && req[k]) begin
                win_idx = IDX_W'(k);
                found   = 1'b1;
            end
        end
        if (req[promo_idx]) begin
            win_idx = promo_idx;
        end
    end
endmodule

// File: rtl/exc_vec_select.sv
module exc_vec_select
    import exc_vec_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             por,
    input  logic             clkmon,
    input  logic             wdog,
    input  logic             trap,
    input  logic             swi,
    input  logic             x_ok,
    input  logic             i_any,
    input  logic [IDX_W-1:0] i_idx,
    output logic             any_pend,
    output logic [15:0]      vec
);
    logic [15:0] i_vec;

    assign i_vec    = VEC_I_TOP - 16'({i_idx, 1'b0});
    assign any_pend = por | clkmon | wdog | trap | swi | x_ok | i_any;

    always_comb begin
        if (por)         vec = VEC_POR;
        else if (clkmon) vec = VEC_CLKMON;
        else if (wdog)   vec = VEC_WDOG;
        else if (trap)   vec = VEC_TRAP;
        else if (swi)    vec = VEC_SWI;
        else if (x_ok)   vec = VEC_XREQ;
        else             vec = i_vec;
    end
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
    import exc_vec_pkg::*;
#(
    parameter int NUM_I = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_por,
    input  logic             req_clkmon,
    input  logic             req_wdog,
    input  logic             req_trap,
    input  logic             req_swi,
    input  logic             req_x,
    input  logic [NUM_I-1:0] req_i,
    input  logic [NUM_I-1:0] force_i,
    input  logic             mask_i,
    input  logic             mask_x,
    input  logic             low_power,
    input  logic             prio_wr,
    input  logic [7:0]       prio_wdata,
    input  logic             vec_fetch,
    output logic             irq_pending,
    output logic             vec_valid,
    output logic [15:0]      vec_addr,
    output logic             wakeup
);
    localparam int IDX_W = $clog2(NUM_I);

    exc_state_e       state_q, state_d;
    logic [NUM_I-1:0] i_eff;
    logic [IDX_W-1:0] promo_idx, win_idx;
    logic             i_any, x_ok, any_pend, capture;
    logic [15:0]      sel_vec, vec_q;

    assign i_eff = (req_i | force_i) & {NUM_I{~mask_i}};
    assign x_ok  = req_x & ~mask_x;

    exc_prio_reg #(.NUM_I(NUM_I), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .wr_en(prio_wr), .wr_data(prio_wdata),
        .promo_idx(promo_idx)
    );

    exc_i_arbiter #(.NUM_I(NUM_I), .IDX_W(IDX_W)) u_arb (
        .req(i_eff), .promo_idx(promo_idx), .any(i_any), .win_idx(win_idx)
    );

    exc_vec_select #(.IDX_W(IDX_W)) u_sel (
        .por(req_por), .clkmon(req_clkmon), .wdog(req_wdog),
        .trap(req_trap), .swi(req_swi), .x_ok(x_ok),
        .i_any(i_any), .i_idx(win_idx),
        .any_pend(any_pend), .vec(sel_vec)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (vec_fetch && any_pend) state_d = ST_SERVE;
                else if (any_pend)         state_d = ST_PEND;
            end
            ST_PEND: begin
                if (vec_fetch && any_pend) state_d = ST_SERVE;
                else if (!any_pend)        state_d = ST_IDLE;
            end
            ST_SERVE: begin
                if (!vec_fetch) state_d = any_pend ? ST_PEND : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process: vector capture
    assign capture = vec_fetch && any_pend && (state_q != ST_SERVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vec_q <= VEC_POR;
        else if (capture) vec_q <= sel_vec;
    end

    assign vec_addr    = vec_q;
    assign vec_valid   = (state_q == ST_SERVE);
    assign irq_pending = any_pend;
    assign wakeup      = low_power && (req_x || i_any);
endmodule

// File: rtl/exc_vector_ctrl_chk.sv
module exc_vector_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_por,
    input logic        req_trap,
    input logic        req_swi,
    input logic        req_x,
    input logic        low_power,
    input logic        vec_fetch,
    input logic        irq_pending,
    input logic        vec_valid,
    input logic [15:0] vec_addr,
    input logic        wakeup
);
    assert_por_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && req_por && !vec_valid) |=> (vec_valid && vec_addr == 16'hFFFE));

    assert_vec_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[15:8] == 8'hFF && !vec_addr[0]));

    assert_unmaskable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_trap || req_swi || req_por) |-> irq_pending);

    assert_x_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && req_x) |-> wakeup);

    assert_no_wake_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !low_power |-> !wakeup);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_fetch) |=> (vec_valid && $stable(vec_addr)));

    assert_valid_needs_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(vec_fetch));
endmodule

bind exc_vector_ctrl exc_vector_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_por(req_por), .req_trap(req_trap),
    .req_swi(req_swi), .req_x(req_x), .low_power(low_power),
    .vec_fetch(vec_fetch), .irq_pending(irq_pending), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .wakeup(wakeup)
);

// File: tb/exc_vector_ctrl_bench.sv
module exc_vector_ctrl_bench;
    localparam int NUM_I = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_por = 0, req_clkmon = 0, req_wdog = 0;
    logic             req_trap = 0, req_swi = 0, req_x = 0;
    logic [NUM_I-1:0] req_i = '0, force_i = '0;
    logic             mask_i = 0, mask_x = 0, low_power = 0;
    logic             prio_wr = 0;
    logic [7:0]       prio_wdata = '0;
    logic             vec_fetch = 0;
    logic             irq_pending, vec_valid, wakeup;
    logic [15:0]      vec_addr;

    always #10 clk = ~clk;

    exc_vector_ctrl #(.NUM_I(NUM_I)) u_exc_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .req_por(req_por), .req_clkmon(req_clkmon),
        .req_wdog(req_wdog), .req_trap(req_trap), .req_swi(req_swi),
        .req_x(req_x), .req_i(req_i), .force_i(force_i), .mask_i(mask_i),
        .mask_x(mask_x), .low_power(low_power), .prio_wr(prio_wr),
        .prio_wdata(prio_wdata), .vec_fetch(vec_fetch),
        .irq_pending(irq_pending), .vec_valid(vec_valid),
        .vec_addr(vec_addr), .wakeup(wakeup)
    );

    typedef struct {
        logic [15:0] vec;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic mon_prev = 1'b0;

    // monitor: compare each newly captured vector with the queue head
    always @(negedge clk) begin
        if (rst_n && vec_valid && !mon_prev) begin
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected capture: actual %h expected none", vec_addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (vec_addr !== e.vec) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", e.tag, vec_addr, e.vec);
                end
            end
        end
        mon_prev = vec_valid;
    end

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_vec(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one fetch pulse, expected vector goes to the scoreboard
    task automatic fetch_expect(input logic [15:0] vec, input string tag);
        exp_t e;
        e.vec = vec;
        e.tag = tag;
        q.push_back(e);
        vec_fetch = 1'b1;
        @(negedge clk);
        vec_fetch = 1'b0;
        @(negedge clk);
    endtask

    task automatic prio_write(input logic [7:0] b);
        prio_wr    = 1'b1;
        prio_wdata = b;
        @(negedge clk);
        prio_wr    = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_reqs();
        req_por = 0; req_clkmon = 0; req_wdog = 0; req_trap = 0;
        req_swi = 0; req_x = 0; req_i = '0; force_i = '0;
        mask_i = 0; mask_x = 0; low_power = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 missing capture: actual none expected %h", q[0].vec);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_bit("R1 pending", irq_pending, 1'b0);
        chk_bit("R1 valid", vec_valid, 1'b0);
        chk_bit("R1 wakeup", wakeup, 1'b0);

        // R3 I-source vectors and order
        req_i = 8'b0000_1000; @(negedge clk);
        fetch_expect(16'hFFEC, "R3 src3");
        req_i = 8'b0100_0100; @(negedge clk);
        fetch_expect(16'hFFEE, "R3 src2 over src6");
        req_i = 8'b1000_0000; @(negedge clk);
        fetch_expect(16'hFFE4, "R3 src7 lowest");

        // R1/R4 default promotion is source 0
        req_i = 8'b0010_0001; @(negedge clk);
        fetch_expect(16'hFFF2, "R1 default promo src0");

        // R4 promote source 5
        prio_write(8'hE8);
        fetch_expect(16'hFFE8, "R4 promoted src5");
        req_x = 1; @(negedge clk);
        fetch_expect(16'hFFF4, "R2 X over promoted");
        req_x = 0; @(negedge clk);

        // R5 invalid writes ignored
        prio_write(8'hE9);
        prio_write(8'hF4);
        prio_write(8'hE2);
        fetch_expect(16'hFFE8, "R5 invalid writes ignored");

        // R6 I mask blocks all I incl. promoted
        mask_i = 1; @(negedge clk);
        chk_bit("R6 masked pending", irq_pending, 1'b0);
        vec_fetch = 1; @(negedge clk);
        chk_bit("R6 no capture", vec_valid, 1'b0);
        vec_fetch = 0; @(negedge clk);
        req_x = 1; @(negedge clk);
        fetch_expect(16'hFFF4, "R6 X unaffected by mask_i");
        clear_reqs();

        // R7 X mask
        mask_x = 1; req_x = 1; @(negedge clk);
        chk_bit("R7 masked X pending", irq_pending, 1'b0);
        req_i = 8'b0000_0010; @(negedge clk);
        fetch_expect(16'hFFF0, "R7 I wins over masked X");
        clear_reqs();

        // R2 fixed ladder
        req_por = 1; req_clkmon = 1; req_wdog = 1; req_trap = 1;
        req_swi = 1; req_x = 1; req_i = 8'hFF; @(negedge clk);
        fetch_expect(16'hFFFE, "R2 por");
        req_por = 0; @(negedge clk);
        fetch_expect(16'hFFFC, "R2 clkmon");
        req_clkmon = 0; @(negedge clk);
        fetch_expect(16'hFFFA, "R2 wdog");
        req_wdog = 0; @(negedge clk);
        fetch_expect(16'hFFF8, "R2 trap");
        req_trap = 0; @(negedge clk);
        fetch_expect(16'hFFF6, "R2 swi");
        clear_reqs();

        // R8 unmaskable sources
        mask_i = 1; mask_x = 1; req_trap = 1; @(negedge clk);
        chk_bit("R8 trap masked", irq_pending, 1'b1);
        req_trap = 0; req_swi = 1; @(negedge clk);
        chk_bit("R8 swi masked", irq_pending, 1'b1);
        clear_reqs();

        // R9 wakeup
        low_power = 1; mask_x = 1; req_x = 1; @(negedge clk);
        chk_bit("R9 masked X wakes", wakeup, 1'b1);
        req_x = 0; mask_i = 1; req_i = 8'b0000_0100; @(negedge clk);
        chk_bit("R9 masked I no wake", wakeup, 1'b0);
        mask_i = 0; @(negedge clk);
        chk_bit("R9 unmasked I wakes", wakeup, 1'b1);
        low_power = 0; @(negedge clk);
        chk_bit("R9 awake no wakeup", wakeup, 1'b0);
        clear_reqs();

        // R10 hold while fetch stays high
        req_i = 8'b0000_1000; @(negedge clk);
        begin
            exp_t e;
            e.vec = 16'hFFEC;
            e.tag = "R10 capture";
            q.push_back(e);
        end
        vec_fetch = 1; @(negedge clk);
        req_por = 1; @(negedge clk);
        @(negedge clk);
        chk_vec("R10 held during fetch", vec_addr, 16'hFFEC);
        chk_bit("R10 still valid", vec_valid, 1'b1);
        vec_fetch = 0; @(negedge clk);
        chk_bit("R10 released", vec_valid, 1'b0);
        fetch_expect(16'hFFFE, "R10 refetch");
        clear_reqs();

        // R11 force input
        force_i = 8'b0001_0000; @(negedge clk);
        fetch_expect(16'hFFEA, "R11 forced src4");
        mask_i = 1; @(negedge clk);
        chk_bit("R11 forced masked", irq_pending, 1'b0);
        clear_reqs();

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule